// File: doc/BRIEF.md
# Repeat-Mode Instruction Iteration Controller

This block sequences the repeat modes of a processor with 18-bit word addresses. It takes one decoded repeat command and steps through its iterations. Each command carries the variant (single, double or linked), an 8-bit trip count, a 6-bit unsigned address delta, two per-slot increment enables, a 7-bit stop mask and a source select. The source select says whether the count and mask come from the command itself or from a copy of index register zero. For every execution the block presents the effective address of the instruction to run. It waits for the execution unit to report completion together with the indicator flags and a link word. It then either advances the addresses or stops.

The single variant repeats one instruction. The double variant repeats a pair of instructions, and each slot of the pair has its own increment enable. The linked variant follows a chain: each execution returns the address of the next list element, and the chain ends at a zero link. Any variant stops early when an indicator selected by the mask is set after an execution. A double command whose repeat instruction sits at an even address is refused. On completion the block gives a one-cycle done pulse and a reason code. Fetch, execution and memory are outside the block.

Top module: `rpt_iter_ctrl`

## Requirements
- R1: `cmd_ready` is 1 only while the controller is idle and out of reset. A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high. While a sequence runs, `cmd_ready` is 0, and a `cmd_valid` pulse with other field values changes neither `iss_ea` nor the sequence.
- R2: A selected count of 0 runs 256 iterations. A count of N from 1 to 255 runs N iterations. In double mode one iteration is one pair.
- R3: Single mode (`cmd_mode` = 0) issues slot 0 only. The first address is `cmd_ea_a`, and after each execution that does not end the run the address grows by `cmd_delta`, modulo 2^18, whatever the increment enables say. `iss_valid`, `iss_slot` and `iss_ea` hold steady until `exec_done`. `exec_link` has no effect in this mode.
- R4: Double mode (`cmd_mode` = 1) alternates `iss_slot` 0,1,0,1 starting from slot 0. The slots start at `cmd_ea_a` and `cmd_ea_b`. The slot 0 address grows by the delta after each of its executions only when `cmd_inc_a` = 1, and the slot 1 address only when `cmd_inc_b` = 1.
- R5: Mask and indicator bits pair by index. Index 6 is negative, 5 no-carry, 4 nonzero, 3 overflow, 2 plus, 1 carry and 0 zero. Index 6 corresponds to bit 11 and index 0 to bit 17 of an 18-bit word numbered with bit 0 as the MSB. When `exec_ind & mask` is nonzero at an execution, the run ends with reason 1.
- R6: Linked mode (`cmd_mode` = 2) issues slot 0. The first address is `cmd_ea_a`, and each later address is the `exec_link` returned by the previous execution; the delta is unused. A returned link of 0 ends the run with reason 2.
- R7: With `cmd_use_inst` = 1, the count and mask come from `cmd_count` and `cmd_mask`. With `cmd_use_inst` = 0, the count comes from bits 0–7 (`cmd_xreg[17:10]`) and the mask from bits 11–17 (`cmd_xreg[6:0]`), and `cmd_count` and `cmd_mask` are ignored.
- R8: A double command with `cmd_rpt_addr[0]` = 0 issues nothing. The cycle after acceptance shows `done` = 1 with reason 3.
- R9: `done` is high for exactly one cycle. That cycle follows the edge that takes the terminating `exec_done`, or the edge that accepts an illegal command. Reason codes are 0 count exhausted, 1 condition met, 2 zero link and 3 illegal start. When several causes meet at one execution, condition beats zero link, and zero link beats count.
- R10: After reset the block is idle: `cmd_ready` = 1, `iss_valid` = 0 and `done` = 0.
- R11: Mode code 3 behaves exactly as single mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_mode | input | 2 | 0 single, 1 double, 2 linked, 3 as single |
| cmd_use_inst | input | 1 | 1: count/mask from command, 0: from index register copy |
| cmd_count | input | 8 | Trip count from command (0 means 256) |
| cmd_mask | input | 7 | Stop-condition mask from command |
| cmd_xreg | input | 18 | Index register zero contents |
| cmd_delta | input | 6 | Unsigned address delta |
| cmd_inc_a | input | 1 | Double mode: advance slot 0 address |
| cmd_inc_b | input | 1 | Double mode: advance slot 1 address |
| cmd_rpt_addr | input | 18 | Address of the repeat instruction (oddness checked) |
| cmd_ea_a | input | 18 | Initial address of slot 0 |
| cmd_ea_b | input | 18 | Initial address of slot 1 |
| iss_valid | output | 1 | An execution is requested |
| iss_slot | output | 1 | Slot being issued |
| iss_ea | output | 18 | Effective address to execute |
| exec_done | input | 1 | Issued execution finished |
| exec_ind | input | 7 | Indicators after the execution |
| exec_link | input | 18 | Link word returned by the execution |
| done | output | 1 | One-cycle completion pulse |
| done_reason | output | 2 | Completion reason code |

## Verification
`iss_valid` and the first address appear in the cycle after the accepting edge. Each later address appears in the cycle after the edge that takes a non-final `exec_done`. `done` and its reason appear in the cycle after the terminating `exec_done` edge, or after the edge that accepts an illegal command, and drop one cycle later. The bench drives and samples on falling edges and waits the stated number of edges before each comparison. It inserts random stall cycles before `exec_done` and checks that the issued address holds through them.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_DOUBLE = 2'd1,
    MODE_LINKED = 2'd2,
    MODE_RSVD   = 2'd3
  } rpt_mode_e;

  typedef enum logic [1:0] {
    END_COUNT   = 2'd0,
    END_COND    = 2'd1,
    END_ZLINK   = 2'd2,
    END_ILLEGAL = 2'd3
  } rpt_end_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rpt_state_e;

endpackage

// File: rtl/rpt_rst_sync.sv
// Asserts asynchronously, releases on the clock after STAGES edges.
module rpt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/rpt_cmd_decode.sv
// Picks count and mask source, expands the trip count, normalises the
// mode and flags an illegal double start.
module rpt_cmd_decode
  import rpt_pkg::*;
#(
  parameter int AW = 18,
  parameter int CW = 8,
  parameter int MW = 7
) (
  input  logic          use_inst,
  input  logic [CW-1:0] inst_count,
  input  logic [MW-1:0] inst_mask,
  input  logic [AW-1:0] xreg,
  input  logic [1:0]    mode_raw,
  input  logic          rpt_addr_lsb,
  output logic [CW:0]   trip,
  output logic [MW-1:0] mask,
  output rpt_mode_e     mode_n,
  output logic          illegal
);

  logic [CW-1:0] cnt_sel;

  always_comb begin
    cnt_sel = use_inst ? inst_count : xreg[AW-1 -: CW];
    mask    = use_inst ? inst_mask  : xreg[MW-1:0];
    if (cnt_sel == '0) begin
      trip = {1'b1, {CW{1'b0}}};
    end else begin
      trip = {1'b0, cnt_sel};
    end
    case (mode_raw)
      2'd1:    mode_n = MODE_DOUBLE;
      2'd2:    mode_n = MODE_LINKED;
      default: mode_n = MODE_SINGLE;
    endcase
    illegal = (mode_n == MODE_DOUBLE) && !rpt_addr_lsb;
  end

endmodule

// File: rtl/rpt_term_eval.sv
// Stop decision after one execution, with cause priority.
module rpt_term_eval
  import rpt_pkg::*;
#(
  parameter int AW = 18,
  parameter int MW = 7
) (
  input  logic [MW-1:0] ind,
  input  logic [MW-1:0] mask,
  input  logic          linked,
  input  logic [AW-1:0] link,
  input  logic          last,
  output logic          stop,
  output rpt_end_e      reason
);

  logic cond_hit;
  logic zlink_hit;

  always_comb begin
    cond_hit  = |(ind & mask);
    zlink_hit = linked && (link == '0);
    stop      = cond_hit || zlink_hit || last;
    if (cond_hit) begin
      reason = END_COND;
    end else if (zlink_hit) begin
      reason = END_ZLINK;
    end else begin
      reason = END_COUNT;
    end
  end

endmodule

// File: rtl/rpt_addr_slot.sv
// One effective-address register: load, add delta or take a link.
module rpt_addr_slot #(
  parameter int AW = 18,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_ea,
  input  logic          step,
  input  logic          take_link,
  input  logic [DW-1:0] delta,
  input  logic [AW-1:0] link,
  output logic [AW-1:0] ea
);

  logic [AW-1:0] ea_q;
  logic [AW-1:0] ea_d;
  logic          ea_en;

  always_comb begin
    ea_en = load || step;
    ea_d  = ea_q;
    if (load) begin
      ea_d = load_ea;
    end else if (step) begin
      if (take_link) begin
        ea_d = link;
      end else begin
        ea_d = ea_q + {{(AW-DW){1'b0}}, delta};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q <= '0;
    end else if (ea_en) begin
      ea_q <= ea_d;
    end
  end

  assign ea = ea_q;

endmodule

// File: rtl/rpt_iter_ctrl.sv
module rpt_iter_ctrl
  import rpt_pkg::*;
#(
  parameter int AW = 18,
  parameter int CW = 8,
  parameter int DW = 6,
  parameter int MW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_mode,
  input  logic          cmd_use_inst,
  input  logic [CW-1:0] cmd_count,
  input  logic [MW-1:0] cmd_mask,
  input  logic [AW-1:0] cmd_xreg,
  input  logic [DW-1:0] cmd_delta,
  input  logic          cmd_inc_a,
  input  logic          cmd_inc_b,
  input  logic [AW-1:0] cmd_rpt_addr,
  input  logic [AW-1:0] cmd_ea_a,
  input  logic [AW-1:0] cmd_ea_b,
  output logic          iss_valid,
  output logic          iss_slot,
  output logic [AW-1:0] iss_ea,
  input  logic          exec_done,
  input  logic [MW-1:0] exec_ind,
  input  logic [AW-1:0] exec_link,
  output logic          done,
  output logic [1:0]    done_reason
);

  localparam int TW    = CW + 1;
  localparam int NSLOT = 2;

  // ---------------- reset ----------------
  logic rst_n_s;

  rpt_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  // ---------------- command decode ----------------
  logic [TW-1:0] dec_trip;
  logic [MW-1:0] dec_mask;
  rpt_mode_e     dec_mode;
  logic          dec_illegal;

  rpt_cmd_decode #(.AW(AW), .CW(CW), .MW(MW)) u_dec (
    .use_inst     (cmd_use_inst),
    .inst_count   (cmd_count),
    .inst_mask    (cmd_mask),
    .xreg         (cmd_xreg),
    .mode_raw     (cmd_mode),
    .rpt_addr_lsb (cmd_rpt_addr[0]),
    .trip         (dec_trip),
    .mask         (dec_mask),
    .mode_n       (dec_mode),
    .illegal      (dec_illegal)
  );

  // ---------------- state ----------------
  rpt_state_e    state_q, state_d;
  rpt_mode_e     mode_q;
  logic [MW-1:0] mask_q;
  logic [TW-1:0] rem_q, rem_d;
  logic          slot_q, slot_d;
  logic          inc_a_q, inc_b_q;
  logic [DW-1:0] delta_q;
  logic          done_q, done_d;
  rpt_end_e      reason_q, reason_d;

  logic          accept;
  logic          fire;
  logic          pair_end;
  logic          last;
  logic          advance;
  logic          rem_en;
  logic          slot_en;
  logic          stop;
  rpt_end_e      term_reason;

  assign cmd_ready = (state_q == ST_IDLE) && rst_n_s;
  assign accept    = cmd_valid && cmd_ready;
  assign fire      = (state_q == ST_RUN) && exec_done;
  assign pair_end  = (mode_q != MODE_DOUBLE) || slot_q;
  assign last      = (rem_q == {{(TW-1){1'b0}}, 1'b1}) && pair_end;
  assign advance   = fire && !stop;

  rpt_term_eval #(.AW(AW), .MW(MW)) u_term (
    .ind    (exec_ind),
    .mask   (mask_q),
    .linked (mode_q == MODE_LINKED),
    .link   (exec_link),
    .last   (last),
    .stop   (stop),
    .reason (term_reason)
  );

  // ---------------- address slots ----------------
  logic [NSLOT-1:0] slot_step;
  logic [AW-1:0]    slot_init [NSLOT];
  logic [AW-1:0]    slot_ea   [NSLOT];

  always_comb begin
    slot_init[0] = cmd_ea_a;
    slot_init[1] = cmd_ea_b;
    slot_step[0] = advance && !slot_q &&
                   ((mode_q != MODE_DOUBLE) || inc_a_q);
    slot_step[1] = advance && slot_q && inc_b_q;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    rpt_addr_slot #(.AW(AW), .DW(DW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .load      (accept),
      .load_ea   (slot_init[g]),
      .step      (slot_step[g]),
      .take_link (mode_q == MODE_LINKED),
      .delta     (delta_q),
      .link      (exec_link),
      .ea        (slot_ea[g])
    );
  end

  // ---------------- next state ----------------
  always_comb begin
    state_d  = state_q;
    rem_d    = rem_q;
    slot_d   = slot_q;
    done_d   = 1'b0;
    reason_d = reason_q;
    rem_en   = 1'b0;
    slot_en  = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          rem_d   = dec_trip;
          rem_en  = 1'b1;
          slot_d  = 1'b0;
          slot_en = 1'b1;
          if (dec_illegal) begin
            done_d   = 1'b1;
            reason_d = END_ILLEGAL;
          end else begin
            state_d = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (fire) begin
          if (stop) begin
            state_d  = ST_IDLE;
            done_d   = 1'b1;
            reason_d = term_reason;
          end else begin
            if (pair_end) begin
              rem_d  = rem_q - {{(TW-1){1'b0}}, 1'b1};
              rem_en = 1'b1;
            end
            if (mode_q == MODE_DOUBLE) begin
              slot_d  = !slot_q;
              slot_en = 1'b1;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q  <= ST_IDLE;
      done_q   <= 1'b0;
      reason_q <= END_COUNT;
    end else begin
      state_q  <= state_d;
      done_q   <= done_d;
      reason_q <= reason_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q  <= MODE_SINGLE;
      mask_q  <= '0;
      inc_a_q <= 1'b0;
      inc_b_q <= 1'b0;
      delta_q <= '0;
    end else if (accept) begin
      mode_q  <= dec_mode;
      mask_q  <= dec_mask;
      inc_a_q <= cmd_inc_a;
      inc_b_q <= cmd_inc_b;
      delta_q <= cmd_delta;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      slot_q <= 1'b0;
    end else if (slot_en) begin
      slot_q <= slot_d;
    end
  end

  // ---------------- outputs ----------------
  assign iss_valid   = (state_q == ST_RUN);
  assign iss_slot    = slot_q;
  assign iss_ea      = slot_q ? slot_ea[1] : slot_ea[0];
  assign done        = done_q;
  assign done_reason = reason_q;

endmodule

// File: rtl/rpt_iter_ctrl_chk.sv
module rpt_iter_ctrl_chk #(
  parameter int AW = 18,
  parameter int MW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_mode,
  input logic [AW-1:0] cmd_rpt_addr,
  input logic          iss_valid,
  input logic          iss_slot,
  input logic [AW-1:0] iss_ea,
  input logic          exec_done,
  input logic [MW-1:0] exec_ind,
  input logic [AW-1:0] exec_link,
  input logic          done,
  input logic [1:0]    done_reason,
  input logic [1:0]    mode_q,
  input logic [MW-1:0] mask_q
);

  // R1: never ready while an execution is being requested
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !iss_valid);

  // R3: issue outputs hold until the execution completes
  p_issue_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !exec_done) |=> (iss_valid && $stable(iss_ea) && $stable(iss_slot)));

  // R3 / R6: only double mode uses slot 1
  p_single_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && (mode_q != 2'd1)) |-> !iss_slot);

  // R5: a selected indicator ends the run with reason 1
  p_cond_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && exec_done && ((exec_ind & mask_q) != '0)) |=>
      (done && (done_reason == 2'd1) && !iss_valid));

  // R6: zero link in linked mode ends the run with reason 2
  p_zero_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && exec_done && (mode_q == 2'd2) && (exec_link == '0) &&
     ((exec_ind & mask_q) == '0)) |=> (done && (done_reason == 2'd2)));

  // R8: even start address for a double command is refused
  p_illegal_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_mode == 2'd1) && !cmd_rpt_addr[0]) |=>
      (done && (done_reason == 2'd3) && !iss_valid));

  // R9: done lasts a single cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: done follows a completed execution or an accepted command
  p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(iss_valid && exec_done) || $past(cmd_valid && cmd_ready)));

endmodule

bind rpt_iter_ctrl rpt_iter_ctrl_chk #(.AW(AW), .MW(MW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_mode     (cmd_mode),
  .cmd_rpt_addr (cmd_rpt_addr),
  .iss_valid    (iss_valid),
  .iss_slot     (iss_slot),
  .iss_ea       (iss_ea),
  .exec_done    (exec_done),
  .exec_ind     (exec_ind),
  .exec_link    (exec_link),
  .done         (done),
  .done_reason  (done_reason),
  .mode_q       (mode_q),
  .mask_q       (mask_q)
);

// File: tb/tb_rpt_iter_ctrl.sv
`timescale 1ns/1ps
module tb_rpt_iter_ctrl;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [1:0]  cmd_mode;
  logic        cmd_use_inst;
  logic [7:0]  cmd_count;
  logic [6:0]  cmd_mask;
  logic [17:0] cmd_xreg;
  logic [5:0]  cmd_delta;
  logic        cmd_inc_a;
  logic        cmd_inc_b;
  logic [17:0] cmd_rpt_addr;
  logic [17:0] cmd_ea_a;
  logic [17:0] cmd_ea_b;
  logic        iss_valid;
  logic        iss_slot;
  logic [17:0] iss_ea;
  logic        exec_done;
  logic [6:0]  exec_ind;
  logic [17:0] exec_link;
  logic        done;
  logic [1:0]  done_reason;

  int n_chk;
  int n_fail;

  rpt_iter_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_mode(cmd_mode),
    .cmd_use_inst(cmd_use_inst), .cmd_count(cmd_count), .cmd_mask(cmd_mask),
    .cmd_xreg(cmd_xreg), .cmd_delta(cmd_delta), .cmd_inc_a(cmd_inc_a),
    .cmd_inc_b(cmd_inc_b), .cmd_rpt_addr(cmd_rpt_addr), .cmd_ea_a(cmd_ea_a),
    .cmd_ea_b(cmd_ea_b), .iss_valid(iss_valid), .iss_slot(iss_slot),
    .iss_ea(iss_ea), .exec_done(exec_done), .exec_ind(exec_ind),
    .exec_link(exec_link), .done(done), .done_reason(done_reason)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk_eq(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected reason for a run end, per R9 priority.
  function automatic logic [1:0] exp_reason(input bit cnd, input bit zl);
    if (cnd) return 2'd1;
    if (zl)  return 2'd2;
    return 2'd0;
  endfunction

  task automatic run_cmd(input logic [1:0] mode, input bit use_inst,
                         input logic [7:0] cnt, input logic [6:0] msk,
                         input logic [17:0] xr, input logic [5:0] dl,
                         input bit ia, input bit ib,
                         input logic [17:0] raddr, input logic [17:0] eaa,
                         input logic [17:0] eab, input int stop_at,
                         input logic [6:0] hit, input int zl_at, input bit poke);
    logic [7:0]  ec;
    logic [6:0]  em;
    logic [17:0] xa, xb, lk, want_ea;
    logic [6:0]  ind;
    int          trip, total, slot;
    bit          dbl, lnk, ill, cnd, zl, lst;
    string       tg;

    ec    = use_inst ? cnt : xr[17:10];
    em    = use_inst ? msk : xr[6:0];
    trip  = (ec == 8'd0) ? 256 : int'(ec);
    dbl   = (mode == 2'd1);
    lnk   = (mode == 2'd2);
    ill   = dbl && !raddr[0];
    total = dbl ? 2 * trip : trip;
    xa    = eaa;
    xb    = eab;
    tg    = dbl ? "R4" : (lnk ? "R6" : (mode == 2'd3 ? "R11" : "R3"));

    @(negedge clk);
    chk_eq("R1", "ready while idle", 32'(cmd_ready), 32'd1);
    cmd_mode = mode; cmd_use_inst = use_inst; cmd_count = cnt; cmd_mask = msk;
    cmd_xreg = xr; cmd_delta = dl; cmd_inc_a = ia; cmd_inc_b = ib;
    cmd_rpt_addr = raddr; cmd_ea_a = eaa; cmd_ea_b = eab;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;

    if (ill) begin
      chk_eq("R8", "done after even double start", 32'(done), 32'd1);
      chk_eq("R8", "reason illegal", 32'(done_reason), 32'd3);
      chk_eq("R8", "nothing issued", 32'(iss_valid), 32'd0);
      @(negedge clk);
      chk_eq("R9", "done one cycle", 32'(done), 32'd0);
      return;
    end

    for (int k = 0; k < 1000; k++) begin
      slot = dbl ? (k % 2) : 0;
      if (poke && k == 0) begin
        cmd_valid = 1'b1;
        cmd_ea_a  = ~eaa;
        chk_eq("R1", "not ready while busy", 32'(cmd_ready), 32'd0);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_ea_a  = eaa;
      end
      repeat ($urandom % 3) @(negedge clk);
      want_ea = (slot == 1) ? xb : xa;
      chk_eq(tg, "issue valid", 32'(iss_valid), 32'd1);
      chk_eq(tg, "issue slot", 32'(iss_slot), 32'(slot));
      chk_eq(tg, "issue address", 32'(iss_ea), 32'(want_ea));

      ind = (k == stop_at) ? hit : (7'($urandom) & ~em);
      if (k == zl_at) lk = 18'd0;
      else if (lnk)   lk = 18'($urandom) | 18'd1;
      else            lk = 18'($urandom);
      cnd = ((ind & em) != 7'd0);
      zl  = lnk && (lk == 18'd0);
      lst = (k == total - 1);

      exec_done = 1'b1; exec_ind = ind; exec_link = lk;
      @(posedge clk);
      @(negedge clk);
      exec_done = 1'b0;

      if (cnd || zl || lst) begin
        chk_eq("R9", "done at run end", 32'(done), 32'd1);
        chk_eq(cnd ? "R5" : (zl ? "R6" : "R2"), "done reason",
               32'(done_reason), 32'(exp_reason(cnd, zl)));
        chk_eq("R9", "issue stops", 32'(iss_valid), 32'd0);
        @(negedge clk);
        chk_eq("R9", "done one cycle", 32'(done), 32'd0);
        break;
      end
      chk_eq("R9", "no early done", 32'(done), 32'd0);

      if (lnk) begin
        xa = lk;
      end else if (slot == 0) begin
        if (!dbl || ia) xa = xa + {12'd0, dl};
      end else begin
        if (ib) xb = xb + {12'd0, dl};
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7531));
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_mode = 2'd0; cmd_use_inst = 1'b1;
    cmd_count = '0; cmd_mask = '0; cmd_xreg = '0; cmd_delta = '0;
    cmd_inc_a = 1'b0; cmd_inc_b = 1'b0; cmd_rpt_addr = '0; cmd_ea_a = '0;
    cmd_ea_b = '0; exec_done = 1'b0; exec_ind = '0; exec_link = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_eq("R10", "ready after reset", 32'(cmd_ready), 32'd1);
    chk_eq("R10", "no issue after reset", 32'(iss_valid), 32'd0);
    chk_eq("R10", "no done after reset", 32'(done), 32'd0);

    // R2 R3: count 0 gives 256, address wraps modulo 2^18
    run_cmd(2'd0, 1, 8'd0, 7'd0, 18'd0, 6'd1, 0, 0, 18'd1, 18'h3FF80, 18'd0, -1, 7'd0, -1, 0);
    // R3: single mode advances even with both enables clear
    run_cmd(2'd0, 1, 8'd4, 7'd0, 18'd0, 6'd5, 0, 0, 18'd2, 18'd100, 18'd0, -1, 7'd0, 2, 0);
    // R4: double mode, each enable combination
    run_cmd(2'd1, 1, 8'd3, 7'd0, 18'd0, 6'd2, 1, 1, 18'd7, 18'd10, 18'd500, -1, 7'd0, -1, 0);
    run_cmd(2'd1, 1, 8'd3, 7'd0, 18'd0, 6'd3, 1, 0, 18'd9, 18'd20, 18'd600, -1, 7'd0, -1, 0);
    run_cmd(2'd1, 1, 8'd3, 7'd0, 18'd0, 6'd4, 0, 1, 18'd11, 18'd30, 18'd700, -1, 7'd0, -1, 0);
    // R8: even start for double
    run_cmd(2'd1, 1, 8'd3, 7'd0, 18'd0, 6'd4, 1, 1, 18'd12, 18'd30, 18'd700, -1, 7'd0, -1, 0);
    // R5: plus (index 2) selected and raised at execution 3
    run_cmd(2'd0, 1, 8'd10, 7'b0000100, 18'd0, 6'd1, 0, 0, 18'd1, 18'd0, 18'd0, 3, 7'b0000100, -1, 0);
    // R5: unselected indicators do not stop
    run_cmd(2'd0, 1, 8'd4, 7'b1000000, 18'd0, 6'd1, 0, 0, 18'd1, 18'd0, 18'd0, 2, 7'b0111111, -1, 0);
    // R6: zero link ends a linked run
    run_cmd(2'd2, 1, 8'd9, 7'd0, 18'd0, 6'd7, 0, 0, 18'd1, 18'd40, 18'd0, -1, 7'd0, 2, 0);
    // R9: condition beats zero link at the same execution
    run_cmd(2'd2, 1, 8'd9, 7'b0000001, 18'd0, 6'd7, 0, 0, 18'd1, 18'd40, 18'd0, 1, 7'b0000001, 1, 0);
    // R9: condition beats count on the last execution
    run_cmd(2'd0, 1, 8'd3, 7'b0100000, 18'd0, 6'd1, 0, 0, 18'd1, 18'd0, 18'd0, 2, 7'b0100000, -1, 0);
    // R6: linked run to count end, delta unused
    run_cmd(2'd2, 1, 8'd5, 7'd0, 18'd0, 6'd9, 1, 1, 18'd1, 18'd50, 18'd0, -1, 7'd0, -1, 0);
    // R7: count and mask from the index register copy
    run_cmd(2'd0, 0, 8'd200, 7'd0, {8'd3, 3'd0, 7'b0000001}, 6'd1, 0, 0, 18'd1, 18'd0, 18'd0, -1, 7'd0, -1, 0);
    run_cmd(2'd0, 0, 8'd200, 7'd0, {8'd6, 3'd5, 7'b0000001}, 6'd1, 0, 0, 18'd1, 18'd0, 18'd0, 2, 7'b0000001, -1, 0);
    // R2 R7: zero count in the index register copy
    run_cmd(2'd0, 0, 8'd1, 7'd0, {8'd0, 3'd0, 7'd0}, 6'd2, 0, 0, 18'd1, 18'd0, 18'd0, -1, 7'd0, -1, 0);
    // R11: mode code 3 behaves as single
    run_cmd(2'd3, 1, 8'd4, 7'd0, 18'd0, 6'd3, 0, 1, 18'd1, 18'd70, 18'd900, -1, 7'd0, -1, 0);
    // R1: command offered while busy is ignored
    run_cmd(2'd1, 1, 8'd2, 7'd0, 18'd0, 6'd1, 1, 1, 18'd3, 18'd80, 18'd90, -1, 7'd0, -1, 1);

    // Random runs over every mode and source
    for (int t = 0; t < 250; t++) begin
      logic [17:0] xr;
      logic [17:0] ra;
      xr = 18'($urandom);
      xr[17:10] = 8'($urandom % 6 + 1);
      ra = 18'($urandom);
      if ($urandom % 8 != 0) ra[0] = 1'b1;
      run_cmd(2'($urandom), 1'($urandom), 8'($urandom % 6 + 1), 7'($urandom),
              xr, 6'($urandom), 1'($urandom), 1'($urandom), ra,
              18'($urandom), 18'($urandom), int'($urandom % 14),
              7'($urandom), int'($urandom % 14), 1'($urandom % 10 == 0));
    end

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule